// File: doc/BRIEF.md
# Variable-Length Instruction Aligner

This block sits between an instruction fetch unit and a decoder. It receives a big-endian stream of 16-bit halfwords and cuts it into whole instructions. The first halfword of each instruction alone sets how long that instruction is. Bits [15:10] of that halfword form the 6-bit primary opcode, and bit 15 is the first bit fetched. When the escape-mode enable is high, the eight lowest primary opcodes are taken over as length markers. When it is low, every instruction is an ordinary two-halfword word.

Once the block has collected the right number of halfwords, it presents one right-aligned instruction word of up to 64 bits together with a class code. A variable-length block marker leaves the block as a single two-halfword unit with its own class. The body of the block is the job of the logic downstream. A flush input discards a partly collected instruction, so that the next halfword accepted starts a new one.

Top module: `ilen_aligner`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high while `flush` is low.
- R2: While `esc_en` is low at an instruction's first halfword, that instruction takes two halfwords and has class code 1, whatever its primary opcode.
- R3: With `esc_en` high, primary opcode 0 or 1 gives a one-halfword instruction with class code 0.
- R4: With `esc_en` high, primary opcode 2 or 3 gives a three-halfword instruction with class code 2.
- R5: With `esc_en` high, primary opcode 4 or 5 gives a four-halfword instruction with class code 3.
- R6: With `esc_en` high, primary opcode 6 or 7 gives a two-halfword block marker with class code 4.
- R7: With `esc_en` high, any primary opcode from 8 to 63 gives a two-halfword instruction with class code 1.
- R8: `out_insn` holds the instruction right-aligned. The first halfword is the most significant occupied halfword, the later ones follow in order of arrival, and all unoccupied upper bits are zero.
- R9: While `out_valid` is high and `out_ready` is low, the output holds its values and `in_ready` is low. No halfword is lost, duplicated or reordered.
- R10: While `flush` is high, `in_ready` is low. Any partly collected instruction is discarded, and the next accepted halfword is treated as a first halfword.
- R11: The class codes are 0 for one halfword, 1 for a plain word, 2 for three halfwords, 3 for four halfwords and 4 for a block marker. No other code appears on `out_cls`.
- R12: An instruction appears on the output in the cycle after its last halfword is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| esc_en | input | 1 | Escape-mode enable, sampled at each first halfword |
| flush | input | 1 | Discard the partial instruction and stall intake |
| in_valid | input | 1 | Halfword present |
| in_ready | output | 1 | Halfword accepted when high together with in_valid |
| in_hw | input | 16 | Incoming halfword, big-endian order |
| out_valid | output | 1 | Aligned instruction present |
| out_ready | input | 1 | Consumer takes the instruction |
| out_insn | output | 64 | Right-aligned instruction word |
| out_cls | output | 3 | Class code |

## Verification
The bench sends one instruction for each opcode pair with escape mode on. It also sends low opcodes with escape mode off, which separates the length table from the plain-word fallback. High opcodes sent with escape mode on show that only the eight lowest values are taken over. A long mixed run under pseudo-random backpressure, with escape mode switching between instructions, shows whether any halfword is lost or reordered while the output is held. A flush in the middle of a four-halfword instruction, followed by short instructions, shows that alignment starts again on the next halfword.

// File: rtl/ilen_pkg.sv
package ilen_pkg;

    typedef enum logic [2:0] {
        CLS_C16  = 3'd0,
        CLS_W32  = 3'd1,
        CLS_W48  = 3'd2,
        CLS_W64  = 3'd3,
        CLS_VBLK = 3'd4
    } ilen_cls_e;

    // halfwords occupied by an instruction of a given class
    function automatic int unsigned hw_count(ilen_cls_e c);
        case (c)
            CLS_C16:  return 1;
            CLS_W48:  return 3;
            CLS_W64:  return 4;
            default:  return 2;
        endcase
    endfunction

endpackage

// File: rtl/ilen_classify.sv
module ilen_classify
    import ilen_pkg::*;
#(
    parameter int OPC_W    = 6,
    parameter int ESC_SPAN = 8
) (
    input  logic [OPC_W-1:0] opc,
    input  logic             esc_en,
    output ilen_cls_e        cls
);
    localparam int GRP_W = $clog2(ESC_SPAN);

    logic in_span;
    assign in_span = (opc < OPC_W'(ESC_SPAN));

    always_comb begin
        cls = CLS_W32;
        if (esc_en && in_span) begin
            // opcodes are taken over in pairs; the pair index picks the length
            case (opc[GRP_W-1:1])
                2'd0:    cls = CLS_C16;
                2'd1:    cls = CLS_W48;
                2'd2:    cls = CLS_W64;
                default: cls = CLS_VBLK;
            endcase
        end
    end

endmodule

// File: rtl/ilen_gather.sv
module ilen_gather
    import ilen_pkg::*;
#(
    parameter int HW_W   = 16,
    parameter int MAX_HW = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   take,
    input  logic                   flush,
    input  logic [HW_W-1:0]        hw,
    input  ilen_cls_e              first_cls,
    output logic                   done,
    output logic [HW_W*MAX_HW-1:0] word,
    output ilen_cls_e              word_cls
);
    localparam int INSN_W = HW_W * MAX_HW;
    localparam int CNT_W  = $clog2(MAX_HW + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [INSN_W-1:0] acc;
        ilen_cls_e         cls;
    } gat_st_t;

    gat_st_t st_d, st_q;
    logic [INSN_W-1:0] acc_new;
    ilen_cls_e         cur_cls;
    logic [CNT_W-1:0]  need;

    always_comb begin
        st_d    = st_q;
        done    = 1'b0;
        cur_cls = (st_q.cnt == '0) ? first_cls : st_q.cls;
        acc_new = (st_q.cnt == '0) ? INSN_W'(hw)
                                   : {st_q.acc[INSN_W-HW_W-1:0], hw};
        need    = CNT_W'(hw_count(cur_cls));
        if (flush) begin
            st_d.cnt = '0;
        end else if (take) begin
            st_d.acc = acc_new;
            st_d.cls = cur_cls;
            if (st_q.cnt + CNT_W'(1) == need) begin
                done     = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
        word     = acc_new;
        word_cls = cur_cls;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.acc <= '0;
            st_q.cls <= CLS_W32;
        end else begin
            st_q <= st_d;
        end
    end

    // R10: a flush leaves no partial instruction behind
    p_flush_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> st_q.cnt == '0);

    // R8: the fill count never reaches the widest instruction
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CNT_W'(MAX_HW));

endmodule

// File: rtl/ilen_outreg.sv
module ilen_outreg
    import ilen_pkg::*;
#(
    parameter int INSN_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [INSN_W-1:0] word,
    input  ilen_cls_e         cls,
    input  logic              out_ready,
    output logic              can_load,
    output logic              out_valid,
    output logic [INSN_W-1:0] out_insn,
    output ilen_cls_e         out_cls
);
    typedef struct packed {
        logic              vld;
        logic [INSN_W-1:0] insn;
        ilen_cls_e         cls;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        can_load = !st_q.vld || out_ready;
        if (load) begin
            st_d.vld  = 1'b1;
            st_d.insn = word;
            st_d.cls  = cls;
        end else if (out_ready) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.vld  <= 1'b0;
            st_q.insn <= '0;
            st_q.cls  <= CLS_W32;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_insn  = st_q.insn;
    assign out_cls   = st_q.cls;

    // R9: a held instruction stays unchanged until it is taken
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_insn) && $stable(out_cls)));

    // R9: nothing is loaded over a held instruction
    p_no_overwrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !load);

endmodule

// File: rtl/ilen_aligner.sv
module ilen_aligner
    import ilen_pkg::*;
#(
    parameter int HW_W     = 16,
    parameter int MAX_HW   = 4,
    parameter int OPC_W    = 6,
    parameter int ESC_SPAN = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   esc_en,
    input  logic                   flush,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [HW_W-1:0]        in_hw,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [HW_W*MAX_HW-1:0] out_insn,
    output logic [2:0]             out_cls
);
    localparam int INSN_W = HW_W * MAX_HW;

    ilen_cls_e          first_cls;
    ilen_cls_e          g_cls;
    ilen_cls_e          o_cls;
    logic               take;
    logic               done;
    logic               can_load;
    logic [INSN_W-1:0]  g_word;

    assign in_ready = !flush && can_load;
    assign take     = in_valid && in_ready;
    assign out_cls  = o_cls;

    ilen_classify #(.OPC_W(OPC_W), .ESC_SPAN(ESC_SPAN)) u_cls (
        .opc    (in_hw[HW_W-1 -: OPC_W]),
        .esc_en (esc_en),
        .cls    (first_cls)
    );

    ilen_gather #(.HW_W(HW_W), .MAX_HW(MAX_HW)) u_gat (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .flush     (flush),
        .hw        (in_hw),
        .first_cls (first_cls),
        .done      (done),
        .word      (g_word),
        .word_cls  (g_cls)
    );

    ilen_outreg #(.INSN_W(INSN_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (done),
        .word      (g_word),
        .cls       (g_cls),
        .out_ready (out_ready),
        .can_load  (can_load),
        .out_valid (out_valid),
        .out_insn  (out_insn),
        .out_cls   (o_cls)
    );

    // R9: intake stalls behind a held output
    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R10: no halfword is accepted during a flush
    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !in_ready);

    // R11: only the five defined class codes leave the block
    p_cls_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_cls <= 3'd4);

    // R8: a one-halfword instruction has zero upper bits
    p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_cls == 3'd0) |-> out_insn[INSN_W-1:HW_W] == '0);

    // R8: two-halfword units have zero upper bits
    p_word_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_cls == 3'd1 || out_cls == 3'd4)) |-> out_insn[INSN_W-1:2*HW_W] == '0);

endmodule

// File: tb/ilen_aligner_tb.sv
module ilen_aligner_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        esc_en;
    logic        flush;
    logic        in_valid;
    logic        in_ready;
    logic [15:0] in_hw;
    logic        out_valid;
    logic        out_ready;
    logic [63:0] out_insn;
    logic [2:0]  out_cls;

    always #2 clk = ~clk;

    ilen_aligner u_dut (
        .clk(clk), .rst_n(rst_n), .esc_en(esc_en), .flush(flush),
        .in_valid(in_valid), .in_ready(in_ready), .in_hw(in_hw),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_insn(out_insn), .out_cls(out_cls)
    );

    int          total = 0;
    int          bad   = 0;
    bit          bp_mode = 1'b0;
    bit          finished = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [66:0] expq[$];
    string       reqq[$];

    // consumer readiness changes just after each rising edge
    initial out_ready = 1'b1;
    always @(posedge clk) begin
        #1;
        lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = bp_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    task automatic check(input bit ok, input string req, input logic [66:0] act, input logic [66:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_cls(input bit esc, input logic [15:0] h);
        logic [5:0] opc;
        opc = h[15:10];
        if (!esc || opc > 6'd7) return 3'd1;
        case (opc[2:1])
            2'd0:    return 3'd0;
            2'd1:    return 3'd2;
            2'd2:    return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

    function automatic int exp_len(input logic [2:0] c);
        case (c)
            3'd0:    return 1;
            3'd2:    return 3;
            3'd3:    return 4;
            default: return 2;
        endcase
    endfunction

    // called at a falling edge; returns at the falling edge after acceptance
    task automatic put_hw(input logic [15:0] h);
        in_valid = 1'b1;
        in_hw    = h;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
    endtask

    task automatic send(input bit esc, input logic [15:0] h0, input string req);
        logic [2:0]  c;
        logic [63:0] w;
        logic [15:0] h;
        int          n;
        c = exp_cls(esc, h0);
        n = exp_len(c);
        w = 64'(h0);
        for (int i = 1; i < n; i++) begin
            h = h0 + 16'(16'h0123 * i);
            w = {w[47:0], h};
        end
        expq.push_back({c, w});
        reqq.push_back(req);
        esc_en = esc;
        put_hw(h0);
        for (int i = 1; i < n; i++) begin
            put_hw(h0 + 16'(16'h0123 * i));
        end
    endtask

    task automatic idle_drain();
        in_valid = 1'b0;
        while (expq.size() != 0) @(negedge clk);
    endtask

    // monitor: pops the scoreboard and watches stalls
    logic        prev_stall = 1'b0;
    logic [66:0] prev_out;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (prev_stall)
                check(out_valid && {out_cls, out_insn} == prev_out, "R9 hold",
                      {out_cls, out_insn}, prev_out);
            if (out_valid && !out_ready)
                check(!in_ready, "R9 stall", 67'(in_ready), 67'(0));
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R9 extra instruction", {out_cls, out_insn}, 67'(0));
                end else begin
                    logic [66:0] e;
                    string       r;
                    e = expq.pop_front();
                    r = reqq.pop_front();
                    check({out_cls, out_insn} == e, r, {out_cls, out_insn}, e);
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_out   = {out_cls, out_insn};
        end
    end

    task automatic summary();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R9 actual=hung expected=drained");
            summary();
        end
    end

    initial begin
        rst_n    = 1'b0;
        esc_en   = 1'b0;
        flush    = 1'b0;
        in_valid = 1'b0;
        in_hw    = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!out_valid && in_ready, "R1 reset", {65'(0), out_valid, in_ready}, 67'b01);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && in_ready, "R1 after release", {65'(0), out_valid, in_ready}, 67'b01);

        // R2: escape mode off, low opcodes are plain words
        send(1'b0, {6'd0, 10'h155}, "R2 opc0");
        send(1'b0, {6'd3, 10'h0AA}, "R2 opc3");
        send(1'b0, {6'd6, 10'h3C3}, "R2 opc6");
        // R3: one-halfword instructions, R8 zero upper bits
        send(1'b1, {6'd0, 10'h2B1}, "R3 R8 opc0");
        send(1'b1, {6'd1, 10'h3FF}, "R3 R8 opc1");
        // R4 / R5 / R6 / R7, R11 codes
        send(1'b1, {6'd2, 10'h101}, "R4 R11 opc2");
        send(1'b1, {6'd3, 10'h0F0}, "R4 R8 opc3");
        send(1'b1, {6'd4, 10'h111}, "R5 R11 opc4");
        send(1'b1, {6'd5, 10'h222}, "R5 R8 opc5");
        send(1'b1, {6'd6, 10'h333}, "R6 R11 opc6");
        send(1'b1, {6'd7, 10'h044}, "R6 opc7");
        send(1'b1, {6'd8, 10'h055}, "R7 opc8");
        send(1'b1, {6'd63, 10'h066}, "R7 opc63");
        send(1'b1, {6'd31, 10'h077}, "R7 opc31");
        idle_drain();

        // R12: output in the cycle after the last halfword
        send(1'b1, {6'd0, 10'h1A5}, "R12 data");
        check(out_valid, "R12 latency", 67'(out_valid), 67'(1));
        in_valid = 1'b0;
        @(negedge clk);
        idle_drain();

        // R10: flush in the middle of a four-halfword instruction
        esc_en = 1'b1;
        put_hw({6'd4, 10'h0AB});
        put_hw(16'hBEEF);
        flush    = 1'b1;
        in_valid = 1'b1;
        in_hw    = {6'd0, 10'h3EE};
        #1;
        check(!in_ready, "R10 ready low", 67'(in_ready), 67'(0));
        @(negedge clk);
        flush = 1'b0;
        send(1'b1, {6'd0, 10'h0C3}, "R10 restart");
        send(1'b1, {6'd2, 10'h0C4}, "R10 restart long");
        idle_drain();

        // R9: mixed run under backpressure with escape mode changing
        bp_mode = 1'b1;
        for (int k = 0; k < 80; k++) begin
            logic [5:0] opc;
            opc = (k % 3 == 0) ? 6'((k * 11) % 64) : 6'(k % 8);
            send(k % 7 != 3, {opc, 10'(k * 37)}, "R9 stream");
        end
        in_valid = 1'b0;
        bp_mode  = 1'b0;
        idle_drain();
        repeat (4) @(negedge clk);
        check(expq.size() == 0 && !out_valid, "R9 drained",
              {66'(expq.size()), out_valid}, 67'(0));
        summary();
    end

endmodule